// File: doc/BRIEF.md
# Low-Speed Serial Bus Packet Receiver

This block turns the two wires of a low-speed USB link into a stream of bytes. A local clock samples both lines at about eight ticks per bit. After a two-flop synchroniser, a phase counter is reloaded on every transition of the negative line, so that each bit is sampled near its centre even when the sender's rate drifts by about a percent. The receiver waits for the idle state and then for the first K level. It follows the alternating sync field and starts the packet once it sees two K bits in a row.

From then on it NRZI-decodes each bit sample, discards the bit that follows six decoded ones, and packs the remaining bits LSB-first into bytes. Each byte is presented for one cycle on a valid strobe. The end of a packet is a single-ended zero confirmed over two bit samples. At that point any partly filled byte is flushed, and the block pulses an end strobe that carries the byte count. A byte budget guards against runaway packets. Protocol decoding above the byte level is left to the consumer.

Top module: `lsrx_top`

## Requirements
- R1: While reset is high and on the first cycle after it, every strobe output (`rx_start`, `rx_valid`, `rx_end`, `rx_ovf`, `rx_err`) is low.
- R2: Sync is accepted only when two consecutive bit samples show K (D- low, D+ high). Two consecutive J samples (D- high, D+ low) during sync send the block back to waiting for a K, with no `rx_start` and no bytes.
- R3: A data bit decodes to 1 when D- holds the level it had at the previous bit sample and to 0 when it changed. The first data bit is compared against the final K of sync. Bits fill bytes LSB-first, and each complete byte is presented on `rx_byte` with a one-cycle `rx_valid`.
- R4: Once six consecutive decoded ones have been counted, the next bit is dropped and the count restarts. The run counter starts at zero with the first data bit.
- R5: Bytes are still received correctly when every fourth bit lasts one tick more, or one tick less, than the nominal period.
- R6: A bit sample with both lines low, followed at the next bit sample by both lines low with D+ never high in between, ends the packet. `rx_end` then pulses for one cycle and `rx_count` holds the number of bytes presented in that packet. A packet with no data gives a count of 0.
- R7: At end of packet, a partial byte of n bits (1 to 7) is presented first. Its bits sit in positions 0 to n-1, the upper bits are zero, and it is included in `rx_count`.
- R8: If D+ goes high between the two low D- samples, `rx_err` pulses instead of `rx_end`, and the next packet is received normally.
- R9: At most MAX_BYTES bytes are presented per packet. A further complete or partial byte raises a one-cycle `rx_ovf` instead of `rx_valid`, and no `rx_end` follows. A packet of exactly MAX_BYTES bytes ends normally.
- R10: `rx_start` pulses once per accepted sync. After an end, error or overflow the block receives the next packet normally.
- R11: At most one of `rx_end`, `rx_ovf`, `rx_err` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, about TICKS per bit |
| rst | input | 1 | Synchronous active-high reset |
| usb_dp | input | 1 | D+ line, asynchronous |
| usb_dm | input | 1 | D- line, asynchronous |
| rx_start | output | 1 | One-cycle pulse when sync is accepted |
| rx_valid | output | 1 | One-cycle byte strobe |
| rx_byte | output | 8 | Received byte, LSB first on the wire |
| rx_end | output | 1 | One-cycle end-of-packet strobe |
| rx_count | output | $clog2(MAX_BYTES+1) | Bytes in the packet, valid with rx_end |
| rx_ovf | output | 1 | Byte budget exceeded, packet aborted |
| rx_err | output | 1 | Unconfirmed single-ended zero, packet aborted |

## Verification
A phase counter that has drifted, or an NRZI reference level left stale, corrupts a byte within one byte time. The bench sees this on the very next `rx_valid`. A run counter that drops too early or too late shifts every later bit, so all following bytes of the packet mismatch, and a stretched-period packet shows sampling slip within seven bit times. Errors in the end detection or the byte budget show up as a missing or extra `rx_end`, a wrong `rx_count`, or a wrong `rx_ovf` or `rx_err` at the packet boundary.

// File: rtl/lsrx_pkg.sv
package lsrx_pkg;
    localparam int BYTE_W    = 8;
    localparam int STUFF_RUN = 6;

    typedef enum logic [2:0] {
        ST_HUNT,   // waiting for idle J
        ST_WAITK,  // waiting for the first J-to-K edge
        ST_SYNC,   // following the sync field
        ST_DATA,   // receiving payload bits
        ST_DRAIN   // aborted, waiting for the line to go SE0
    } rx_state_e;

    typedef struct packed {
        logic start;
        logic valid;
        logic fin;
        logic ovf;
        logic err;
    } rx_evt_t;

    function automatic logic is_j(input logic dp, input logic dm);
        return dm & ~dp;
    endfunction

    function automatic logic is_k(input logic dp, input logic dm);
        return dp & ~dm;
    endfunction

    function automatic logic is_se0(input logic dp, input logic dm);
        return ~dp & ~dm;
    endfunction
endpackage

// File: rtl/lsrx_sync.sv
module lsrx_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[g] <= RST_VAL;
            else     stage_q[g] <= (g == 0) ? d_in : stage_q[(g == 0) ? 0 : g - 1];
        end
    end

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/lsrx_phase.sv
module lsrx_phase #(
    parameter  int TICKS = 8,
    localparam int PH_W  = $clog2(TICKS),
    localparam int HALF  = TICKS / 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic edge_o,
    output logic samp_o
);
    logic            line_d;
    logic [PH_W-1:0] ph_q;

    assign edge_o = line_in ^ line_d;
    assign samp_o = (ph_q == PH_W'(HALF));

    always_ff @(posedge clk) begin
        if (rst) begin
            line_d <= 1'b1;
            ph_q   <= '0;
        end else begin
            line_d <= line_in;
            if (edge_o)                      ph_q <= PH_W'(1);
            else if (ph_q == PH_W'(TICKS-1)) ph_q <= '0;
            else                             ph_q <= ph_q + 1'b1;
        end
    end
endmodule

// File: rtl/lsrx_unpack.sv
module lsrx_unpack
    import lsrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              bit_stb,
    input  logic              bit_val,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_o,
    output logic [BYTE_W-1:0] part_buf,
    output logic [2:0]        part_n
);
    logic [2:0]        ones_q;
    logic [2:0]        idx_q;
    logic [BYTE_W-1:0] buf_q;

    assign part_buf = buf_q;
    assign part_n   = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_q <= '0; idx_q <= '0; buf_q <= '0;
            byte_done <= 1'b0; byte_o <= '0;
        end else if (clr) begin
            ones_q <= '0; idx_q <= '0; buf_q <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (bit_stb) begin
                if (ones_q == 3'(STUFF_RUN)) begin
                    ones_q <= '0;
                end else begin
                    ones_q <= bit_val ? ones_q + 1'b1 : 3'd0;
                    if (idx_q == 3'd7) begin
                        byte_o    <= {bit_val, buf_q[6:0]};
                        byte_done <= 1'b1;
                        buf_q     <= '0;
                        idx_q     <= '0;
                    end else begin
                        buf_q[idx_q] <= bit_val;
                        idx_q        <= idx_q + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/lsrx_top.sv
module lsrx_top
    import lsrx_pkg::*;
#(
    parameter  int TICKS     = 8,
    parameter  int MAX_BYTES = 8,
    localparam int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              usb_dp,
    input  logic              usb_dm,
    output logic              rx_start,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_end,
    output logic [CNT_W-1:0]  rx_count,
    output logic              rx_ovf,
    output logic              rx_err
);
    logic [1:0] line_s;
    logic       dp_s, dm_s, dm_edge, samp;

    lsrx_sync #(.W(2), .STAGES(2), .RST_VAL(2'b01)) sync_i (
        .clk(clk), .rst(rst), .d_in({usb_dp, usb_dm}), .d_out(line_s));
    assign dp_s = line_s[1];
    assign dm_s = line_s[0];

    lsrx_phase #(.TICKS(TICKS)) phase_i (
        .clk(clk), .rst(rst), .line_in(dm_s), .edge_o(dm_edge), .samp_o(samp));

    rx_state_e         state_q;
    rx_evt_t           evt_q;
    logic              prev_q, pend_q, dp_hi_q;
    logic [CNT_W-1:0]  left_q, total_q, count_q;
    logic [BYTE_W-1:0] byte_q;

    logic              se0_now, dp_seen, bit_stb, bit_val, up_clr, up_done;
    logic [BYTE_W-1:0] up_byte, part_buf;
    logic [2:0]        part_n;

    assign se0_now = is_se0(dp_s, dm_s);
    assign dp_seen = dp_hi_q | dp_s;
    assign bit_stb = (state_q == ST_DATA) && samp && !pend_q && !se0_now;
    assign bit_val = (dm_s == prev_q);
    assign up_clr  = (state_q != ST_DATA);

    lsrx_unpack unpack_i (
        .clk(clk), .rst(rst), .clr(up_clr), .bit_stb(bit_stb), .bit_val(bit_val),
        .byte_done(up_done), .byte_o(up_byte), .part_buf(part_buf), .part_n(part_n));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            evt_q   <= '0;
            prev_q  <= 1'b1;
            pend_q  <= 1'b0;
            dp_hi_q <= 1'b0;
            left_q  <= CNT_W'(MAX_BYTES);
            total_q <= '0;
            count_q <= '0;
            byte_q  <= '0;
        end else begin
            evt_q   <= '0;
            dp_hi_q <= samp ? 1'b0 : dp_seen;
            unique case (state_q)
                ST_HUNT:  if (is_j(dp_s, dm_s)) state_q <= ST_WAITK;
                ST_WAITK: if (dm_edge && is_k(dp_s, dm_s)) begin
                    state_q <= ST_SYNC;
                    prev_q  <= 1'b1;
                end
                ST_SYNC: if (samp) begin
                    prev_q <= dm_s;
                    if (se0_now) state_q <= ST_HUNT;
                    else if (!dm_s && !prev_q) begin
                        state_q     <= ST_DATA;
                        evt_q.start <= 1'b1;
                        left_q      <= CNT_W'(MAX_BYTES);
                        total_q     <= '0;
                        pend_q      <= 1'b0;
                    end else if (dm_s && prev_q) state_q <= ST_WAITK;
                end
                ST_DATA: begin
                    if (up_done) begin
                        if (left_q == '0) begin
                            evt_q.ovf <= 1'b1;
                            state_q   <= ST_DRAIN;
                        end else begin
                            evt_q.valid <= 1'b1;
                            byte_q      <= up_byte;
                            left_q      <= left_q - 1'b1;
                            total_q     <= total_q + 1'b1;
                        end
                    end
                    if (samp) begin
                        if (pend_q) begin
                            pend_q  <= 1'b0;
                            state_q <= ST_HUNT;
                            if (se0_now && !dp_seen) begin
                                if (part_n == 3'd0) begin
                                    evt_q.fin <= 1'b1;
                                    count_q   <= total_q;
                                end else if (left_q == '0) begin
                                    evt_q.ovf <= 1'b1;
                                end else begin
                                    evt_q.valid <= 1'b1;
                                    evt_q.fin   <= 1'b1;
                                    byte_q      <= part_buf;
                                    count_q     <= total_q + 1'b1;
                                end
                            end else begin
                                evt_q.err <= 1'b1;
                            end
                        end else if (se0_now) begin
                            pend_q <= 1'b1;
                        end else begin
                            prev_q <= dm_s;
                        end
                    end
                end
                ST_DRAIN: if (se0_now) state_q <= ST_HUNT;
                default:  state_q <= ST_HUNT;
            endcase
        end
    end

    assign rx_start = evt_q.start;
    assign rx_valid = evt_q.valid;
    assign rx_end   = evt_q.fin;
    assign rx_ovf   = evt_q.ovf;
    assign rx_err   = evt_q.err;
    assign rx_byte  = byte_q;
    assign rx_count = count_q;
endmodule

// File: rtl/lsrx_chk.sv
module lsrx_chk #(
    parameter int MAX_BYTES = 8,
    parameter int CNT_W     = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_start,
    input logic             rx_valid,
    input logic             rx_end,
    input logic [CNT_W-1:0] rx_count,
    input logic             rx_ovf,
    input logic             rx_err
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1
    always @(posedge clk) begin
        if (rst_q === 1'b1 && rst === 1'b0)
            reset_quiet_chk: assert (!rx_valid && !rx_start && !rx_end && !rx_ovf && !rx_err);
    end

    // R11
    term_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_end, rx_ovf, rx_err}));

    // R3
    valid_gap_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R10
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_start |=> !rx_start);

    // R10
    start_alone_chk: assert property (@(posedge clk) disable iff (rst)
        rx_start |-> !rx_valid && !rx_end && !rx_ovf && !rx_err);

    // R9
    count_limit_chk: assert property (@(posedge clk) disable iff (rst)
        rx_end |-> rx_count <= CNT_W'(MAX_BYTES));
endmodule

bind lsrx_top lsrx_chk #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .rx_start(rx_start), .rx_valid(rx_valid),
    .rx_end(rx_end), .rx_count(rx_count), .rx_ovf(rx_ovf), .rx_err(rx_err));

// File: tb/lsrx_top_tb_top.sv
`timescale 1ns/1ps
module lsrx_top_tb_top;
    localparam int TICKS     = 8;
    localparam int MAX_BYTES = 8;
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);

    logic clk = 1'b0, rst = 1'b1, usb_dp = 1'b0, usb_dm = 1'b1;
    logic rx_start, rx_valid, rx_end, rx_ovf, rx_err;
    logic [7:0] rx_byte;
    logic [CNT_W-1:0] rx_count;

    always #4 clk = ~clk;

    lsrx_top #(.TICKS(TICKS), .MAX_BYTES(MAX_BYTES)) dut_i (
        .clk(clk), .rst(rst), .usb_dp(usb_dp), .usb_dm(usb_dm),
        .rx_start(rx_start), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_end(rx_end), .rx_count(rx_count), .rx_ovf(rx_ovf), .rx_err(rx_err));

    int checks = 0, fails = 0;
    int n_start = 0, n_end = 0, n_ovf = 0, n_err = 0, last_count = 0;
    int bit_no = 0, stretch = 0;
    logic [7:0] exp_q[$];
    logic [7:0] tx_q[$];
    string cur_req = "R1";

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model: each presented byte must match the next expected one
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL %s: actual=%0h expected=none", cur_req, rx_byte);
                end else begin
                    if (rx_byte !== exp_q[0]) begin
                        fails++;
                        $display("FAIL %s: actual=%0h expected=%0h", cur_req, rx_byte, exp_q[0]);
                    end
                    void'(exp_q.pop_front());
                end
            end
            if (rx_start) n_start++;
            if (rx_ovf)   n_ovf++;
            if (rx_err)   n_err++;
            if (rx_end) begin n_end++; last_count = int'(rx_count); end
        end
    end

    task automatic put_level(input logic dp, input logic dm, input int ticks);
        usb_dp = dp; usb_dm = dm;
        repeat (ticks) begin @(posedge clk); #1; end
    endtask

    task automatic line_bit(input logic lvl); // lvl 1 = J, 0 = K
        int t;
        bit_no++;
        t = TICKS;
        if (bit_no % 4 == 0) t = TICKS + stretch;
        put_level(~lvl, lvl, t);
    endtask

    task automatic send_packet(input int xbits, input logic [7:0] xval, input int eop_mode);
        logic lvl;
        int ones;
        logic bits[$];
        logic [7:0] sync_lv;
        sync_lv = 8'b0010_1010;
        repeat (3) line_bit(1'b1);
        for (int i = 0; i < 8; i++) line_bit(sync_lv[i]);
        foreach (tx_q[k]) for (int i = 0; i < 8; i++) bits.push_back(tx_q[k][i]);
        for (int i = 0; i < xbits; i++) bits.push_back(xval[i]);
        lvl = 1'b0; ones = 0;
        foreach (bits[k]) begin
            if (!bits[k]) lvl = ~lvl;
            line_bit(lvl);
            ones = bits[k] ? ones + 1 : 0;
            if (ones == 6) begin lvl = ~lvl; line_bit(lvl); ones = 0; end
        end
        if (eop_mode == 0) put_level(1'b0, 1'b0, 2 * TICKS);
        else begin
            put_level(1'b0, 1'b0, TICKS + 1);
            put_level(1'b1, 1'b0, 2);
            put_level(1'b0, 1'b0, TICKS - 3);
        end
        repeat (4) line_bit(1'b1);
    endtask

    task automatic run_pkt(input string req, input int xbits, input logic [7:0] xval, input int eop_mode);
        int emitted, s0, e0, o0, r0;
        bit ovf;
        emitted = 0; ovf = 0;
        s0 = n_start; e0 = n_end; o0 = n_ovf; r0 = n_err;
        cur_req = req;
        foreach (tx_q[k]) if (!ovf) begin
            if (emitted < MAX_BYTES) begin exp_q.push_back(tx_q[k]); emitted++; end
            else ovf = 1;
        end
        if (!ovf && eop_mode == 0 && xbits > 0) begin
            if (emitted < MAX_BYTES) begin
                exp_q.push_back(xval & (8'hFF >> (8 - xbits)));
                emitted++;
            end else ovf = 1;
        end
        send_packet(xbits, xval, eop_mode);
        chk({req, " start"}, n_start - s0, 1);
        chk({req, " end"}, n_end - e0, (!ovf && eop_mode == 0) ? 1 : 0);
        chk({req, " ovf"}, n_ovf - o0, ovf ? 1 : 0);
        chk({req, " err"}, n_err - r0, (!ovf && eop_mode == 1) ? 1 : 0);
        chk({req, " bytes left"}, exp_q.size(), 0);
        if (!ovf && eop_mode == 0) chk({req, " count"}, last_count, emitted);
        exp_q.delete();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int s0;
        #1;
        repeat (4) begin @(posedge clk); #1; end
        // R1: quiet during reset
        chk("R1 valid", rx_valid, 0);
        chk("R1 strobes", rx_start | rx_end | rx_ovf | rx_err, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after", rx_valid | rx_start | rx_end | rx_ovf | rx_err, 0);
        repeat (20) begin @(posedge clk); #1; end

        // R3: plain bytes, NRZI and LSB-first packing
        tx_q = '{8'hA5, 8'h3C, 8'h00, 8'h81};
        run_pkt("R3", 0, 8'h00, 0);
        // R4: long runs of ones force stuffed bits
        tx_q = '{8'hFF, 8'hFF, 8'h7F, 8'h01, 8'hFE};
        run_pkt("R4", 0, 8'h00, 0);

        // R2: sync broken by two J samples is ignored
        cur_req = "R2";
        s0 = n_start;
        repeat (3) line_bit(1'b1);
        line_bit(1'b0); line_bit(1'b1); line_bit(1'b0); line_bit(1'b1); line_bit(1'b1);
        repeat (6) line_bit(1'b1);
        chk("R2 no start", n_start - s0, 0);
        tx_q = '{8'h12};
        run_pkt("R10 after R2", 0, 8'h00, 0);

        // R5: drifting bit period, slow then fast
        stretch = 1;
        tx_q = '{8'hFF, 8'h00, 8'h55, 8'hF0, 8'h7E};
        run_pkt("R5 slow", 0, 8'h00, 0);
        stretch = -1;
        run_pkt("R5 fast", 0, 8'h00, 0);
        stretch = 0;

        // R7: partial byte flushed at end
        tx_q = '{8'hC3, 8'h99};
        run_pkt("R7", 5, 8'h16, 0);
        // R6: packet without data
        tx_q.delete();
        run_pkt("R6 empty", 0, 8'h00, 0);

        // R8: D+ pulse between the two low D- samples
        tx_q = '{8'h5A};
        run_pkt("R8", 0, 8'h00, 1);
        tx_q = '{8'h33, 8'hCC};
        run_pkt("R10 after R8", 0, 8'h00, 0);

        // R9: byte budget
        tx_q = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A};
        run_pkt("R9 over", 0, 8'h00, 0);
        tx_q = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
        run_pkt("R9 exact", 0, 8'h00, 0);
        run_pkt("R9 partial over", 3, 8'h05, 0);
        tx_q = '{8'hE7};
        run_pkt("R10 after R9", 0, 8'h00, 0);

        finish_run();
    end
endmodule